// File: doc/BRIEF.md
# Security-Banked System Control Register

This block is a 32-bit system control register for a processor that runs in a secure world and a non-secure world. Some enable fields are banked. The block keeps one copy of each of these fields for each world, and the security qualifier on an access selects which copy it reads or writes. Three fields are shared. Either world can read them, but only a secure access can change them. The remaining bit positions are fixed at one or at zero.

Accesses use a simple port. A write takes effect at the clock edge on which the write enable is high. A read is combinational and composes the full 32-bit word from the stored state.

The block also drives registered control outputs: instruction-cache enable, branch-prediction enable, high vectors, big-endian mode, round-robin replacement and the PC-load interworking mode. These outputs take the banked fields from the copy that belongs to the processor's current world. A vector base address follows from the high-vector output. Two external straps supply the reset values of the high-vector field and the endianness field.

Top module: `sysctl_bank_reg`

## Requirements
- R1: The banked fields are vector-high (bit 13), icache (bit 12), predict (bit 11), rom-protect (bit 9) and mmu-protect (bit 8). Each has a separate secure copy and non-secure copy. A write with `acc_secure`=1 changes only the secure copy, and a write with `acc_secure`=0 changes only the non-secure copy. A read returns the copy selected by `acc_secure`.
- R2: The shared fields are pc-load mode (bit 15), round-robin (bit 14) and big-endian (bit 7). A write with `acc_secure`=1 updates them. A write with `acc_secure`=0 leaves them unchanged. Reads from either world return them.
- R3: Bits 16, 6:4 and 3 always read as one, and writes to them have no effect.
- R4: Bits 31:17, 10 and 2:0 always read as zero, and writes to them have no effect.
- R5: While `rst` is high at a clock edge, the following reset values load. Icache, predict, rom-protect, mmu-protect, pc-load mode and round-robin all become 0 in both worlds. Vector-high becomes `strap_high_vec` in both copies. Big-endian becomes `strap_big_endian`.
- R6: A write updates the stored fields at the clock edge on which `acc_wr_en` is high. `acc_rdata` reflects the stored state combinationally, and stored fields do not change when no write targets them.
- R7: The control outputs are registered. They are taken from the banked copy of the world given by `cpu_secure` and from the shared fields. They change at the clock edge after a change of `cpu_secure` or of a stored field.
- R8: `out_vec_base` equals `VEC_HIGH_BASE` (default 0xFFFF0000) when `out_high_vec` is 1, and equals `vbar_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_big_endian | input | 1 | Reset value of the big-endian field |
| strap_high_vec | input | 1 | Reset value of both vector-high copies |
| cpu_secure | input | 1 | Current world of the processor (1 = secure) |
| acc_wr_en | input | 1 | Register write enable |
| acc_secure | input | 1 | Security qualifier of the access (1 = secure) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Composed read data for the world given by acc_secure |
| vbar_in | input | 32 | Vector base used when high vectors are off |
| out_icache_en | output | 1 | Instruction cache enable |
| out_bpred_en | output | 1 | Branch prediction enable |
| out_high_vec | output | 1 | High vectors selected |
| out_big_endian | output | 1 | Big-endian word-invariant memory |
| out_rr_repl | output | 1 | Round-robin cache replacement |
| out_l4_mode | output | 1 | PC loads do not change the T bit |
| out_vec_base | output | 32 | Selected exception vector base |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a high vector base of 0xFFFF0000. With these, the fixed read-back pattern, the field positions and the high-vector address can all be compared against literal words. The stimulus interleaves secure and non-secure writes with reads from the other world. This exposes leaks between the two banked copies and non-secure changes to shared fields. A second reset with the straps reversed checks that the reset values follow the straps. Toggling `cpu_secure` checks the one-cycle lag of the outputs.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned REG_W = 32;

    // bit positions (software-visible layout)
    localparam int unsigned POS_L4   = 15;
    localparam int unsigned POS_RR   = 14;
    localparam int unsigned POS_V    = 13;
    localparam int unsigned POS_I    = 12;
    localparam int unsigned POS_Z    = 11;
    localparam int unsigned POS_R    = 9;
    localparam int unsigned POS_S    = 8;
    localparam int unsigned POS_B    = 7;

    // positions that always read back as one
    localparam logic [REG_W-1:0] FIXED_ONES = (REG_W'(1) << 16) | REG_W'(32'h0000_0078);

    typedef struct packed {
        logic vhigh;
        logic icache;
        logic predict;
        logic romprot;
        logic mmuprot;
    } banked_t;

    typedef struct packed {
        logic pcload;
        logic rrobin;
        logic bigend;
    } shared_t;

    typedef enum logic {
        WORLD_NSEC = 1'b0,
        WORLD_SEC  = 1'b1
    } world_e;

    function automatic banked_t pick_banked(input logic [REG_W-1:0] w);
        banked_t b;
        b.vhigh   = w[POS_V];
        b.icache  = w[POS_I];
        b.predict = w[POS_Z];
        b.romprot = w[POS_R];
        b.mmuprot = w[POS_S];
        return b;
    endfunction

    function automatic shared_t pick_shared(input logic [REG_W-1:0] w);
        shared_t s;
        s.pcload = w[POS_L4];
        s.rrobin = w[POS_RR];
        s.bigend = w[POS_B];
        return s;
    endfunction

    function automatic logic [REG_W-1:0] compose_word(input banked_t b, input shared_t s);
        logic [REG_W-1:0] w;
        w         = FIXED_ONES;
        w[POS_V]  = b.vhigh;
        w[POS_I]  = b.icache;
        w[POS_Z]  = b.predict;
        w[POS_R]  = b.romprot;
        w[POS_S]  = b.mmuprot;
        w[POS_L4] = s.pcload;
        w[POS_RR] = s.rrobin;
        w[POS_B]  = s.bigend;
        return w;
    endfunction

endpackage

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rst_vhigh,
    input  logic    wr_en,
    input  banked_t wr_fields,
    output banked_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            q.vhigh   <= rst_vhigh;
        end else if (wr_en) begin
            q <= wr_fields;
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q)) else $error("bank changed without write"); // R6

endmodule

// File: rtl/sysctl_shared.sv
module sysctl_shared
    import sysctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rst_bigend,
    input  logic    acc_wr_en,
    input  logic    acc_secure,
    input  shared_t wr_fields,
    output shared_t q
);

    logic upd;
    assign upd = acc_wr_en && (world_e'(acc_secure) == WORLD_SEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.bigend <= rst_bigend;
        end else if (upd) begin
            q <= wr_fields;
        end
    end

    AST_NSEC_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (acc_wr_en && !acc_secure) |=> $stable(q)) else $error("non-secure write changed shared field"); // R2

endmodule

// File: rtl/sysctl_ctrl_out.sv
module sysctl_ctrl_out
    import sysctl_pkg::*;
#(
    parameter logic [REG_W-1:0] VEC_HIGH_BASE = 32'hFFFF_0000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_vhigh,
    input  logic             rst_bigend,
    input  logic             cpu_secure,
    input  banked_t          bank_sec,
    input  banked_t          bank_nsec,
    input  shared_t          shared_q,
    input  logic [REG_W-1:0] vbar_in,
    output logic             out_icache_en,
    output logic             out_bpred_en,
    output logic             out_high_vec,
    output logic             out_big_endian,
    output logic             out_rr_repl,
    output logic             out_l4_mode,
    output logic [REG_W-1:0] out_vec_base
);

    banked_t cur_bank;
    assign cur_bank = (world_e'(cpu_secure) == WORLD_SEC) ? bank_sec : bank_nsec;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_icache_en  <= 1'b0;
            out_bpred_en   <= 1'b0;
            out_high_vec   <= rst_vhigh;
            out_big_endian <= rst_bigend;
            out_rr_repl    <= 1'b0;
            out_l4_mode    <= 1'b0;
        end else begin
            out_icache_en  <= cur_bank.icache;
            out_bpred_en   <= cur_bank.predict;
            out_high_vec   <= cur_bank.vhigh;
            out_big_endian <= shared_q.bigend;
            out_rr_repl    <= shared_q.rrobin;
            out_l4_mode    <= shared_q.pcload;
        end
    end

    assign out_vec_base = out_high_vec ? VEC_HIGH_BASE : vbar_in;

endmodule

// File: rtl/sysctl_bank_reg.sv
module sysctl_bank_reg
    import sysctl_pkg::*;
#(
    parameter logic [REG_W-1:0] VEC_HIGH_BASE = 32'hFFFF_0000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_big_endian,
    input  logic             strap_high_vec,
    input  logic             cpu_secure,
    input  logic             acc_wr_en,
    input  logic             acc_secure,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] acc_rdata,
    input  logic [REG_W-1:0] vbar_in,
    output logic             out_icache_en,
    output logic             out_bpred_en,
    output logic             out_high_vec,
    output logic             out_big_endian,
    output logic             out_rr_repl,
    output logic             out_l4_mode,
    output logic [REG_W-1:0] out_vec_base
);

    localparam int unsigned N_WORLDS = 2;

    banked_t bank_q [N_WORLDS];
    banked_t wr_banked;
    shared_t wr_shared;
    shared_t shared_q;
    banked_t bank_sec;
    banked_t bank_nsec;
    banked_t rd_bank;

    assign wr_banked = pick_banked(acc_wdata);
    assign wr_shared = pick_shared(acc_wdata);

    for (genvar g = 0; g < N_WORLDS; g++) begin : g_world
        logic bank_wr;
        assign bank_wr = acc_wr_en && (acc_secure == (g == int'(WORLD_SEC)));
        sysctl_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .rst_vhigh (strap_high_vec),
            .wr_en     (bank_wr),
            .wr_fields (wr_banked),
            .q         (bank_q[g])
        );
    end

    assign bank_sec  = bank_q[int'(WORLD_SEC)];
    assign bank_nsec = bank_q[int'(WORLD_NSEC)];

    sysctl_shared u_shared (
        .clk        (clk),
        .rst        (rst),
        .rst_bigend (strap_big_endian),
        .acc_wr_en  (acc_wr_en),
        .acc_secure (acc_secure),
        .wr_fields  (wr_shared),
        .q          (shared_q)
    );

    assign rd_bank   = acc_secure ? bank_sec : bank_nsec;
    assign acc_rdata = compose_word(rd_bank, shared_q);

    sysctl_ctrl_out #(.VEC_HIGH_BASE(VEC_HIGH_BASE)) u_out (
        .clk            (clk),
        .rst            (rst),
        .rst_vhigh      (strap_high_vec),
        .rst_bigend     (strap_big_endian),
        .cpu_secure     (cpu_secure),
        .bank_sec       (bank_sec),
        .bank_nsec      (bank_nsec),
        .shared_q       (shared_q),
        .vbar_in        (vbar_in),
        .out_icache_en  (out_icache_en),
        .out_bpred_en   (out_bpred_en),
        .out_high_vec   (out_high_vec),
        .out_big_endian (out_big_endian),
        .out_rr_repl    (out_rr_repl),
        .out_l4_mode    (out_l4_mode),
        .out_vec_base   (out_vec_base)
    );

    AST_WORLD_ISOLATION: assert property (@(posedge clk) disable iff (rst)
        (acc_wr_en && !acc_secure) |=> $stable(bank_sec)) else $error("non-secure write reached secure bank"); // R1

    AST_FIXED_ONES: assert property (@(posedge clk) disable iff (rst)
        (acc_rdata[16] && (acc_rdata[6:3] == 4'hF))) else $error("fixed-one bits lost"); // R3

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_rdata[31:17] == '0 && !acc_rdata[10] && acc_rdata[2:0] == 3'b000)) else $error("reserved bits set"); // R4

endmodule

// File: tb/sysctl_bank_reg_tb_top.sv
module sysctl_bank_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;
    localparam int N_VEC      = 8;
    localparam logic [31:0] VBAR = 32'h1234_0000;

    // {write world, wdata, read world, expected read word}
    localparam logic [65:0] VEC [N_VEC] = '{
        {1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0001_FBF8},
        {1'b0, 32'h0000_1000, 1'b0, 32'h0001_D0F8},
        {1'b0, 32'h0000_0000, 1'b1, 32'h0001_FBF8},
        {1'b1, 32'h0000_2800, 1'b1, 32'h0001_2878},
        {1'b0, 32'h0000_C080, 1'b0, 32'h0001_0078},
        {1'b1, 32'h0000_4000, 1'b0, 32'h0001_4078},
        {1'b1, 32'hFFFE_0407, 1'b1, 32'h0001_0078},
        {1'b0, 32'h0000_0300, 1'b0, 32'h0001_0378}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_big_endian = 1'b1;
    logic        strap_high_vec = 1'b0;
    logic        cpu_secure = 1'b0;
    logic        acc_wr_en = 1'b0;
    logic        acc_secure = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [31:0] vbar_in = VBAR;
    logic        out_icache_en, out_bpred_en, out_high_vec, out_big_endian, out_rr_repl, out_l4_mode;
    logic [31:0] out_vec_base;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_bank_reg dut_i (
        .clk(clk), .rst(rst), .strap_big_endian(strap_big_endian), .strap_high_vec(strap_high_vec),
        .cpu_secure(cpu_secure), .acc_wr_en(acc_wr_en), .acc_secure(acc_secure),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .vbar_in(vbar_in),
        .out_icache_en(out_icache_en), .out_bpred_en(out_bpred_en), .out_high_vec(out_high_vec),
        .out_big_endian(out_big_endian), .out_rr_repl(out_rr_repl), .out_l4_mode(out_l4_mode),
        .out_vec_base(out_vec_base)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R5 reset values with straps big-endian=1, high-vec=0
        acc_secure = 1'b1; #1;
        check("R5 reset read secure", acc_rdata, 32'h0001_00F8);
        acc_secure = 1'b0; #1;
        check("R5 reset read non-secure", acc_rdata, 32'h0001_00F8);
        check("R5 reset big-endian out", {31'b0, out_big_endian}, 32'd1);
        check("R5 reset high-vec out", {31'b0, out_high_vec}, 32'd0);
        check("R8 low vector base", out_vec_base, VBAR);

        // table walk: R1 R2 R3 R4 R6
        for (int k = 0; k < N_VEC; k++) begin
            @(negedge clk);
            acc_wr_en  = 1'b1;
            acc_secure = VEC[k][65];
            acc_wdata  = VEC[k][64:33];
            @(negedge clk);
            acc_wr_en  = 1'b0;
            acc_secure = VEC[k][32];
            #1;
            check($sformatf("R1/R2/R3/R4/R6 vector %0d", k), acc_rdata, VEC[k][31:0]);
        end

        // R6: no write, state unchanged
        @(negedge clk); #1;
        check("R6 hold without write", acc_rdata, 32'h0001_0378);

        // R7 output selection and lag
        @(negedge clk);
        acc_wr_en = 1'b1; acc_secure = 1'b1; acc_wdata = 32'h0000_3080;
        @(negedge clk);
        acc_wr_en = 1'b0; cpu_secure = 1'b1;
        #1;
        check("R7 icache lags world change", {31'b0, out_icache_en}, 32'd0);
        @(negedge clk); #1;
        check("R7 secure icache out", {31'b0, out_icache_en}, 32'd1);
        check("R7 secure high-vec out", {31'b0, out_high_vec}, 32'd1);
        check("R7 big-endian out", {31'b0, out_big_endian}, 32'd1);
        check("R7 round-robin out", {31'b0, out_rr_repl}, 32'd0);
        check("R8 high vector base", out_vec_base, 32'hFFFF_0000);
        cpu_secure = 1'b0;
        @(negedge clk); #1;
        check("R7 non-secure icache out", {31'b0, out_icache_en}, 32'd0);
        check("R7 non-secure high-vec out", {31'b0, out_high_vec}, 32'd0);
        check("R8 vector base from input", out_vec_base, VBAR);

        // R5 reset with straps reversed
        @(negedge clk);
        rst = 1'b1; strap_big_endian = 1'b0; strap_high_vec = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        acc_secure = 1'b1; #1;
        check("R5 strap reset read secure", acc_rdata, 32'h0001_2078);
        acc_secure = 1'b0; #1;
        check("R5 strap reset read non-secure", acc_rdata, 32'h0001_2078);
        check("R5 strap reset high-vec out", {31'b0, out_high_vec}, 32'd1);
        check("R5 strap reset big-endian out", {31'b0, out_big_endian}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule